// File: doc/BRIEF.md
# ECC Scrubbing Memory Controller

This block sits in front of a single-port on-chip SRAM and keeps its contents safe against particle-induced upsets. Each data byte is stored as a 13-bit single-error-correct, double-error-detect code word. Every functional read is decoded. A single flipped bit is corrected on the way out, and the repaired word is queued for write-back. A double error is reported with the response.

When the bus port is idle, a background engine walks the memory one word per cycle and decodes each word it visits. Any word with a single-bit error is repaired, so isolated upsets are removed before a second hit can turn them into an uncorrectable pair. Two saturating counters and a sticky flag let software track upset rates while the system runs.

The SRAM is modelled as a behavioural array inside the block. An upset port flips chosen bits of a stored code word, which stands in for a radiation hit.

Top module: `ecc_scrub_ctrl`

## Requirements
- R1: A read request (req_valid=1, req_write=0) returns its byte on rsp_data, with rsp_valid=1, one clock after the request. If any single one of the 13 stored bits has been flipped, the original byte is returned.
- R2: A functional read that finds a single-bit error increments corr_count by one. It also writes the repaired word back on the next cycle with no bus request, so a later read of that word does not count again.
- R3: A functional read of a word with exactly two flipped bits sets rsp_dbl=1 with its response, increments uncorr_count and sets uncorr_flag.
- R4: uncorr_flag stays set until a cycle with err_clear=1. A new double error in that same cycle keeps it set. err_clear never changes either counter.
- R5: During idle cycles the scrub engine visits one word per cycle. A single-bit error it finds is counted in corr_count and repaired, within DEPTH+2 idle cycles of the upset.
- R6: A cycle with req_valid=1 never advances scrubbing, so an upset word stays unvisited while the bus is busy on every cycle.
- R7: The scrub address wraps from DEPTH-1 to 0. A word holding a double error is counted once per full sweep, so DEPTH*k consecutive idle cycles add exactly k to uncorr_count.
- R8: corr_count and uncorr_count stop at 2^CW-1 and never wrap.
- R9: A functional write to the address of a queued write-back cancels that write-back, so the newly written byte survives.
- R10: During reset both counters, uncorr_flag and rsp_valid are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 8 | Corrected read byte |
| rsp_dbl | output | 1 | Response came from an uncorrectable word |
| err_clear | input | 1 | Clears uncorr_flag |
| upset_en | input | 1 | Apply an upset this cycle |
| upset_addr | input | AW | Word hit by the upset |
| upset_mask | input | 13 | Stored bits to flip |
| corr_count | output | CW | Saturating count of corrected errors |
| uncorr_count | output | CW | Saturating count of uncorrectable errors |
| uncorr_flag | output | 1 | Sticky uncorrectable-error flag |

## Verification
A read response and the counter updates it causes appear one clock after the request. Write-backs and scrub visits happen on idle clocks. The bench drives inputs on the falling edge and samples on the following falling edge. A driver queues the expected byte and the expected double-error bit for each read, and a monitor compares the response when rsp_valid rises.

Upsets are injected during a bus cycle to another word, and the target is read on the very next cycle, so scrubbing cannot reach the word first. Scrub results are checked only after a known number of idle clocks. A sweep over DEPTH idle clocks visits each word exactly once, which lets the bench predict exact counter values.

// File: rtl/ecc_scrub_ctrl.sv
module ecc_scrub_ctrl #(
  parameter int DEPTH = 64,
  parameter int CW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_wdata,
  output logic          rsp_valid,
  output logic [7:0]    rsp_data,
  output logic          rsp_dbl,
  input  logic          err_clear,
  input  logic          upset_en,
  input  logic [AW-1:0] upset_addr,
  input  logic [12:0]   upset_mask,
  output logic [CW-1:0] corr_count,
  output logic [CW-1:0] uncorr_count,
  output logic          uncorr_flag
);
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  function automatic logic [12:0] encode(input logic [7:0] d);
    logic [12:0] c;
    c = '0;
    c[3] = d[0]; c[5] = d[1]; c[6] = d[2]; c[7] = d[3];
    c[9] = d[4]; c[10] = d[5]; c[11] = d[6]; c[12] = d[7];
    c[1] = c[3] ^ c[5] ^ c[7] ^ c[9] ^ c[11];
    c[2] = c[3] ^ c[6] ^ c[7] ^ c[10] ^ c[11];
    c[4] = c[5] ^ c[6] ^ c[7] ^ c[12];
    c[8] = c[9] ^ c[10] ^ c[11] ^ c[12];
    c[0] = ^c[12:1];
    return c;
  endfunction

  logic [12:0]   mem [DEPTH];
  logic [AW-1:0] scrub_ptr, wb_addr, rd_addr;
  logic [12:0]   wb_code, raw, fixed;
  logic          wb_pend;
  logic [3:0]    syn;
  logic          par, sgl, dbl;

  wire bus_rd   = req_valid && !req_write;
  wire bus_wr   = req_valid && req_write;
  wire scrub_rd = !req_valid && !wb_pend;
  wire wb_go    = !req_valid && wb_pend;
  wire chk      = bus_rd || scrub_rd;
  wire hit_sgl  = chk && sgl;
  wire hit_dbl  = chk && dbl;

  assign rd_addr = req_valid ? req_addr : scrub_ptr;
  assign raw     = mem[rd_addr];
  assign par     = ^raw;

  always_comb begin
    syn = '0;
    for (int i = 1; i < 13; i++)
      if (raw[i]) syn = syn ^ 4'(i);
  end

  assign sgl   = par && (syn < 4'd13);
  assign dbl   = (!par && syn != 4'd0) || (par && syn >= 4'd13);
  assign fixed = sgl ? (raw ^ (13'(1) << syn)) : raw;

  always_ff @(posedge clk) begin
    if (bus_wr)     mem[req_addr] <= encode(req_wdata);
    else if (wb_go) mem[wb_addr]  <= wb_code;
    if (upset_en)   mem[upset_addr] <= mem[upset_addr] ^ upset_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scrub_ptr    <= '0;
      wb_pend      <= 1'b0;
      wb_addr      <= '0;
      wb_code      <= '0;
      rsp_valid    <= 1'b0;
      rsp_data     <= '0;
      rsp_dbl      <= 1'b0;
      corr_count   <= '0;
      uncorr_count <= '0;
      uncorr_flag  <= 1'b0;
    end else begin
      if (scrub_rd) scrub_ptr <= (scrub_ptr == LAST) ? '0 : scrub_ptr + 1'b1;
      if (hit_sgl) begin
        wb_pend <= 1'b1;
        wb_addr <= rd_addr;
        wb_code <= fixed;
      end else if ((bus_wr && req_addr == wb_addr) || wb_go) begin
        wb_pend <= 1'b0;
      end
      rsp_valid <= bus_rd;
      rsp_dbl   <= bus_rd && dbl;
      if (bus_rd)
        rsp_data <= {fixed[12], fixed[11], fixed[10], fixed[9],
                     fixed[7], fixed[6], fixed[5], fixed[3]};
      if (hit_sgl && corr_count != CMAX)   corr_count   <= corr_count + 1'b1;
      if (hit_dbl && uncorr_count != CMAX) uncorr_count <= uncorr_count + 1'b1;
      if (hit_dbl)        uncorr_flag <= 1'b1;
      else if (err_clear) uncorr_flag <= 1'b0;
    end
  end

  AST_CORR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(corr_count) == CMAX |-> corr_count == CMAX); // R8
  AST_UNCORR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(uncorr_count) == CMAX |-> uncorr_count == CMAX); // R8
  AST_CORR_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    corr_count >= $past(corr_count)); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(uncorr_flag) && !$past(err_clear) |-> uncorr_flag); // R4
  AST_FLAG_ON_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    uncorr_count != $past(uncorr_count) |-> uncorr_flag); // R3
  AST_SCRUB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> $stable(scrub_ptr)); // R6
  AST_WB_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    wb_pend && !req_valid |=> !wb_pend); // R2
  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid) && !$past(req_write)); // R1
endmodule

// File: tb/ecc_scrub_ctrl_tb_top.sv
`timescale 1ns/1ps
module ecc_scrub_ctrl_tb_top;
  localparam int DEPTH = 64;
  localparam int CW    = 8;
  localparam int AW    = $clog2(DEPTH);
  localparam int CMAX  = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic rsp_valid, rsp_dbl, uncorr_flag;
  logic [7:0] rsp_data;
  logic err_clear = 1'b0, upset_en = 1'b0;
  logic [AW-1:0] upset_addr = '0;
  logic [12:0] upset_mask = '0;
  logic [CW-1:0] corr_count, uncorr_count;

  always #10 clk = ~clk;

  ecc_scrub_ctrl #(.DEPTH(DEPTH), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_dbl(rsp_dbl), .err_clear(err_clear),
    .upset_en(upset_en), .upset_addr(upset_addr), .upset_mask(upset_mask),
    .corr_count(corr_count), .uncorr_count(uncorr_count), .uncorr_flag(uncorr_flag));

  int n_chk = 0, n_bad = 0;
  int exp_corr = 0, exp_unc = 0;
  logic [7:0] shadow [DEPTH];
  logic [9:0] exp_q [$];
  string tag_q [$];
  bit done = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R1: actual unexpected response expected none");
      end else begin
        logic [9:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rsp_dbl !== e[8] || (e[9] && rsp_data !== e[7:0])) begin
          n_bad++;
          $display("FAIL %s: actual data %h dbl %b expected data %h dbl %b",
                   t, rsp_data, rsp_dbl, e[7:0], e[8]);
        end
      end
    end
  end

  task automatic idle(input int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_wdata = d;
    shadow[a] = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(input int a, input bit dbl, input string tag);
    req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a);
    exp_q.push_back({~dbl, dbl, shadow[a]});
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic inject(input int dummy, input int a, input logic [12:0] m);
    upset_en = 1'b1; upset_addr = AW'(a); upset_mask = m;
    rd(dummy, 1'b0, "R1");
    upset_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 rsp_valid", rsp_valid, 0);
    check("R10 corr_count", corr_count, 0);
    check("R10 uncorr_count", uncorr_count, 0);
    check("R10 uncorr_flag", uncorr_flag, 0);
    rst_n = 1'b1;
    for (int i = 0; i < DEPTH; i++) wr(i, 8'(i * 37 + 5));
    idle(2);

    foreach (shadow[k]) if (k < 0) $display("unused");
    for (int b = 0; b < 13; b += 3) begin
      inject(1, 10 + b, 13'(1) << b);
      rd(10 + b, 1'b0, "R1");
      idle(1);
      exp_corr++;
      check("R2 count on corrected read", corr_count, exp_corr);
      rd(10 + b, 1'b0, "R2");
      idle(1);
      check("R2 no recount after write-back", corr_count, exp_corr);
    end

    inject(1, 20, 13'h0040);
    rd(20, 1'b0, "R1");
    wr(20, 8'hA5);
    idle(2);
    exp_corr++;
    rd(20, 1'b0, "R9 write survives cancelled write-back");
    idle(1);
    check("R9 corr_count", corr_count, exp_corr);

    inject(1, 30, 13'h0012);
    rd(30, 1'b1, "R3 double reported");
    wr(30, shadow[30]);
    idle(1);
    exp_unc++;
    check("R3 uncorr_count", uncorr_count, exp_unc);
    check("R3 uncorr_flag", uncorr_flag, 1);
    idle(5);
    check("R4 flag sticky", uncorr_flag, 1);
    err_clear = 1'b1; @(negedge clk); err_clear = 1'b0;
    check("R4 flag cleared", uncorr_flag, 0);
    check("R4 counter kept", uncorr_count, exp_unc);

    inject(1, 31, 13'h0201);
    err_clear = 1'b1;
    rd(31, 1'b1, "R3");
    err_clear = 1'b0;
    wr(31, shadow[31]);
    exp_unc++;
    check("R4 set beats clear", uncorr_flag, 1);
    err_clear = 1'b1; @(negedge clk); err_clear = 1'b0;

    inject(1, 40, 13'h0100);
    for (int i = 0; i < 2 * DEPTH; i++) rd(2, 1'b0, "R6");
    check("R6 no scrub while bus busy", corr_count, exp_corr);
    idle(DEPTH + 2);
    exp_corr++;
    check("R5 scrub found error", corr_count, exp_corr);
    rd(40, 1'b0, "R5");
    idle(1);
    check("R5 scrub repaired word", corr_count, exp_corr);

    inject(1, 50, 13'h1008);
    idle(3 * DEPTH);
    exp_unc += 3;
    check("R7 one count per sweep", uncorr_count, exp_unc);
    idle(256 * DEPTH);
    check("R8 uncorr saturates", uncorr_count, CMAX);
    idle(DEPTH);
    check("R8 uncorr held", uncorr_count, CMAX);
    wr(50, shadow[50]);
    err_clear = 1'b1; @(negedge clk); err_clear = 1'b0;

    for (int k = 0; k < 260; k++) begin
      inject(1, 5, 13'(1) << (k % 13));
      rd(5, 1'b0, "R1");
      idle(1);
    end
    check("R8 corr saturates", corr_count, CMAX);
    check("R2 queue drained", exp_q.size(), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule